// File: doc/BRIEF.md
# Position Counter with Compare Latch

This block keeps the position of one motion axis in a wide up/down counter. An upstream pulse decoder hands it a count-enable strobe and a direction bit. The counter steps once per enabled clock and wraps at both ends of its range. Three strobes act on the counter. One loads it from a preload register, one captures its present value into a latch register, and one clears it. The clear is qualified by the state of an index input and the phase inputs, so it fires only in the intended cycle.

Two reference comparators, indexed 0 and 1, watch the live count at all times. Each one gives an active-low equality flag and a match output. The match output either follows equality cycle by cycle or, once set, stays asserted until a clear pulse for that comparator arrives. Software writes the preload register and the two references through a parallel port that has one enable bit per byte. The references have no reset, so a system reset does not change the positions they hold.

Top module: `poscnt_unit`

## Requirements
- R1: While `rst_n` is low, `count_o` and `latch_o` read 0, the preload register is 0, and both held match states are cleared.
- R2: When `step_en` is 1 at a clock edge, `count_o` changes by +1 if `step_dir` is 1 and by -1 if `step_dir` is 0, modulo 2^CNT_W. Counting up from all ones gives 0, and counting down from 0 gives all ones.
- R3: When `ld_stb` is 1 at a clock edge, `count_o` takes the preload value. This wins over a step in the same cycle.
- R4: When `lt_stb` is 1 at a clock edge, `latch_o` takes the value `count_o` held just before that edge. A step or load in the same cycle does not change what is captured.
- R5: With `clr_mode` at 1, `count_o` goes to 0 at an edge where `z_in` is 1, `b_in` is 0, and `a_in` differs from its value at the previous edge (either edge direction). This wins over load and step. If `b_in` is 1 or `z_in` is 0, the counter does not clear.
- R6: A write (`wr_en` at 1) targets the preload register when `wr_sel` is 0, reference 0 when it is 1, and reference 1 when it is 2. Bit k of `wr_be` enables data bits [8k+7:8k]. Bytes whose enable bit is clear keep their old value.
- R7: `eq_n_o[i]` is 0 exactly while `count_o` equals reference i, and 1 otherwise.
- R8: With `hold_mode[i]` at 0, `match_o[i]` is 1 exactly in the cycles where `count_o` equals reference i.
- R9: With `hold_mode[i]` at 1, `match_o[i]` rises with equality and stays at 1 after the count moves on. It drops after a clock edge at which `hclr[i]` is 1, unless the count still equals the reference. A clear wins over an equality seen in the same cycle.
- R10: Reset does not change either reference register. A match occurs at the value that was written before the reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| step_en | input | 1 | Count-enable strobe from the decoder |
| step_dir | input | 1 | Step direction, 1 up, 0 down |
| ld_stb | input | 1 | Load counter from preload register |
| lt_stb | input | 1 | Capture counter into latch register |
| clr_mode | input | 1 | Enables the qualified synchronous clear |
| a_in | input | 1 | Phase A input, edges trigger the clear |
| b_in | input | 1 | Phase B input, must be 0 for a clear |
| z_in | input | 1 | Index input, must be 1 for a clear |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 preload, 1 reference 0, 2 reference 1 |
| wr_data | input | CNT_W | Write data |
| wr_be | input | CNT_W/8 | Byte enables for the write |
| hold_mode | input | 2 | Per comparator: 1 held match, 0 momentary |
| hclr | input | 2 | Per comparator release pulse for a held match |
| count_o | output | CNT_W | Live counter value |
| latch_o | output | CNT_W | Latch register |
| eq_n_o | output | 2 | Active-low equality flags |
| match_o | output | 2 | Match outputs |

## Verification
The bench builds the block with its default 24-bit counter and 8-bit byte lanes, both edges accepted for the clear. Both wrap points are reached in a few cycles by preloading values next to them, and a three-lane enable vector covers partial writes in the middle byte. Reference 1 is placed at all-ones minus one, so a held match is carried across the wrap, released, and then re-armed when the count steps back down. The references are written while reset is asserted and checked again after a second reset, which shows they keep their values.

// File: rtl/poscnt_pkg.sv
package poscnt_pkg;

   // write target codes on the parallel port
   typedef enum logic [1:0] {
      SEL_PRE  = 2'd0,
      SEL_REF0 = 2'd1,
      SEL_REF1 = 2'd2,
      SEL_NONE = 2'd3
   } wsel_e;

   // number of reference comparators in one channel
   localparam int NCMP = 2;

   // clear-edge variants for the qualified clear
   localparam int CLR_BOTH = 0;
   localparam int CLR_RISE = 1;
   localparam int CLR_FALL = 2;

endpackage

// File: rtl/poscnt_regs.sv
module poscnt_regs
   import poscnt_pkg::*;
#(
   parameter int CNT_W  = 24,
   parameter int BYTE_W = 8,
   parameter int NBYTE  = CNT_W / BYTE_W
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [1:0]                  wr_sel,
   input  logic [CNT_W-1:0]            wr_data,
   input  logic [NBYTE-1:0]            wr_be,
   output logic [CNT_W-1:0]            pre_o,
   output logic [NCMP-1:0][CNT_W-1:0]  ref_o
);

   wsel_e            sel;
   logic             pre_hit;
   logic [NCMP-1:0]  ref_hit;

   assign sel     = wsel_e'(wr_sel);
   assign pre_hit = wr_en && (sel == SEL_PRE);
   assign ref_hit = {wr_en && (sel == SEL_REF1), wr_en && (sel == SEL_REF0)};

   for (genvar k = 0; k < NBYTE; k++) begin : g_lane
      localparam int LO = k * BYTE_W;

      logic [BYTE_W-1:0] pre_b;

      // preload lane: cleared by reset
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            pre_b <= '0;
         else if (pre_hit && wr_be[k])
            pre_b <= wr_data[LO +: BYTE_W];
      end
      assign pre_o[LO +: BYTE_W] = pre_b;

      // reference lanes: no reset, the stored position survives it
      for (genvar j = 0; j < NCMP; j++) begin : g_ref
         logic [BYTE_W-1:0] ref_b;
         always_ff @(posedge clk) begin
            if (ref_hit[j] && wr_be[k])
               ref_b <= wr_data[LO +: BYTE_W];
         end
         assign ref_o[j][LO +: BYTE_W] = ref_b;
      end
   end

endmodule

// File: rtl/poscnt_zdet.sv
module poscnt_zdet
   import poscnt_pkg::*;
#(
   parameter int CLR_EDGE = CLR_BOTH
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_mode,
   input  logic a_in,
   input  logic b_in,
   input  logic z_in,
   output logic clr_hit
);

   logic a_prev;
   logic a_edge;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         a_prev <= 1'b0;
      else
         a_prev <= a_in;
   end

   // the parameter picks which edges of A qualify
   if (CLR_EDGE == CLR_RISE) begin : g_rise
      assign a_edge = a_in && !a_prev;
   end else if (CLR_EDGE == CLR_FALL) begin : g_fall
      assign a_edge = !a_in && a_prev;
   end else begin : g_both
      assign a_edge = a_in ^ a_prev;
   end

   assign clr_hit = clr_mode && z_in && !b_in && a_edge;

endmodule

// File: rtl/poscnt_count.sv
module poscnt_count #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             step_dir,
   input  logic             ld_stb,
   input  logic             lt_stb,
   input  logic             clr_hit,
   input  logic [CNT_W-1:0] pre_i,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] latch_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W-1:0] lat_q;

   // priority: qualified clear, then load, then step
   always_comb begin
      cnt_d = cnt_q;
      if (clr_hit)
         cnt_d = '0;
      else if (ld_stb)
         cnt_d = pre_i;
      else if (step_en)
         cnt_d = step_dir ? cnt_q + ONE : cnt_q - ONE;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         lat_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (lt_stb)
            lat_q <= cnt_q;
      end
   end

   assign count_o = cnt_q;
   assign latch_o = lat_q;

endmodule

// File: rtl/poscnt_cmp.sv
module poscnt_cmp #(
   parameter int CNT_W = 24
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] count_i,
   input  logic [CNT_W-1:0] ref_i,
   input  logic             hold_mode,
   input  logic             hclr,
   output logic             eq_n_o,
   output logic             match_o
);

   logic eq;
   logic held_q;

   assign eq = (count_i == ref_i);

   // sticky state: a release pulse wins over a coincident equality
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         held_q <= 1'b0;
      else if (hclr)
         held_q <= 1'b0;
      else if (eq)
         held_q <= 1'b1;
   end

   assign eq_n_o  = !eq;
   assign match_o = hold_mode ? (held_q || eq) : eq;

endmodule

// File: rtl/poscnt_unit.sv
module poscnt_unit
   import poscnt_pkg::*;
#(
   parameter int CNT_W    = 24,
   parameter int BYTE_W   = 8,
   parameter int NBYTE    = CNT_W / BYTE_W,
   parameter int CLR_EDGE = CLR_BOTH
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_en,
   input  logic             step_dir,
   input  logic             ld_stb,
   input  logic             lt_stb,
   input  logic             clr_mode,
   input  logic             a_in,
   input  logic             b_in,
   input  logic             z_in,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [CNT_W-1:0] wr_data,
   input  logic [NBYTE-1:0] wr_be,
   input  logic [1:0]       hold_mode,
   input  logic [1:0]       hclr,
   output logic [CNT_W-1:0] count_o,
   output logic [CNT_W-1:0] latch_o,
   output logic [1:0]       eq_n_o,
   output logic [1:0]       match_o
);

   // elaboration-time parameter checks
   if (CNT_W < 2 || CNT_W > 64) begin : g_bad_width
      $error("poscnt_unit: CNT_W out of range");
   end
   if (BYTE_W < 1 || (CNT_W % BYTE_W) != 0) begin : g_bad_lane
      $error("poscnt_unit: CNT_W must be a multiple of BYTE_W");
   end
   if (NBYTE != CNT_W / BYTE_W) begin : g_bad_nbyte
      $error("poscnt_unit: NBYTE must equal CNT_W/BYTE_W");
   end
   if (CLR_EDGE < CLR_BOTH || CLR_EDGE > CLR_FALL) begin : g_bad_edge
      $error("poscnt_unit: unknown CLR_EDGE variant");
   end

   logic [CNT_W-1:0]           pre_q;
   logic [NCMP-1:0][CNT_W-1:0] ref_q;
   logic                       clr_hit;

   poscnt_regs #(
      .CNT_W (CNT_W),
      .BYTE_W(BYTE_W),
      .NBYTE (NBYTE)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (wr_en),
      .wr_sel (wr_sel),
      .wr_data(wr_data),
      .wr_be  (wr_be),
      .pre_o  (pre_q),
      .ref_o  (ref_q)
   );

   poscnt_zdet #(
      .CLR_EDGE(CLR_EDGE)
   ) u_zdet (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_mode(clr_mode),
      .a_in    (a_in),
      .b_in    (b_in),
      .z_in    (z_in),
      .clr_hit (clr_hit)
   );

   poscnt_count #(
      .CNT_W(CNT_W)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .step_en (step_en),
      .step_dir(step_dir),
      .ld_stb  (ld_stb),
      .lt_stb  (lt_stb),
      .clr_hit (clr_hit),
      .pre_i   (pre_q),
      .count_o (count_o),
      .latch_o (latch_o)
   );

   for (genvar i = 0; i < NCMP; i++) begin : g_cmp
      poscnt_cmp #(
         .CNT_W(CNT_W)
      ) u_cmp (
         .clk      (clk),
         .rst_n    (rst_n),
         .count_i  (count_o),
         .ref_i    (ref_q[i]),
         .hold_mode(hold_mode[i]),
         .hclr     (hclr[i]),
         .eq_n_o   (eq_n_o[i]),
         .match_o  (match_o[i])
      );
   end

endmodule

// File: rtl/poscnt_sva.sv
module poscnt_sva #(
   parameter int CNT_W = 24
) (
   input logic             clk,
   input logic             rst_n,
   input logic             step_en,
   input logic             step_dir,
   input logic             ld_stb,
   input logic             lt_stb,
   input logic             clr_hit,
   input logic [CNT_W-1:0] pre_q,
   input logic [1:0]       hold_mode,
   input logic [1:0]       hclr,
   input logic [CNT_W-1:0] count_o,
   input logic [CNT_W-1:0] latch_o,
   input logic [1:0]       eq_n_o,
   input logic [1:0]       match_o
);

   // R2: a lone step moves the count by one in the chosen direction
   a_r2_step: assert property (@(posedge clk) disable iff (!rst_n)
      (step_en && !ld_stb && !clr_hit) |=>
         (count_o == ($past(step_dir) ? $past(count_o) + CNT_W'(1)
                                      : $past(count_o) - CNT_W'(1))));

   // R3: load copies the preload register, also against a step
   a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_stb && !clr_hit) |=> (count_o == $past(pre_q)));

   // R4: latch captures the value before the edge
   a_r4_latch: assert property (@(posedge clk) disable iff (!rst_n)
      lt_stb |=> (latch_o == $past(count_o)));

   // R5: qualified clear zeroes the counter
   a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_hit |=> (count_o == '0));

   for (genvar i = 0; i < 2; i++) begin : g_chk
      // R8: momentary output is the inverse of the active-low flag
      a_r8_momentary: assert property (@(posedge clk) disable iff (!rst_n)
         !hold_mode[i] |-> (match_o[i] == !eq_n_o[i]));

      // R9: a held match stays until released
      a_r9_held: assert property (@(posedge clk) disable iff (!rst_n)
         (hold_mode[i] && match_o[i] && !hclr[i]) |=>
            (!hold_mode[i] || match_o[i]));
   end

endmodule

bind poscnt_unit poscnt_sva #(.CNT_W(CNT_W)) u_sva (
   .clk      (clk),
   .rst_n    (rst_n),
   .step_en  (step_en),
   .step_dir (step_dir),
   .ld_stb   (ld_stb),
   .lt_stb   (lt_stb),
   .clr_hit  (clr_hit),
   .pre_q    (pre_q),
   .hold_mode(hold_mode),
   .hclr     (hclr),
   .count_o  (count_o),
   .latch_o  (latch_o),
   .eq_n_o   (eq_n_o),
   .match_o  (match_o)
);

// File: tb/poscnt_unit_bench.sv
`timescale 1ns/1ps
module poscnt_unit_bench;

   localparam int W  = 24;
   localparam int NB = 3;
   localparam logic [W-1:0] MSK = {W{1'b1}};

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          step_en = 0, step_dir = 0, ld_stb = 0, lt_stb = 0;
   logic          clr_mode = 0, a_in = 0, b_in = 0, z_in = 0;
   logic          wr_en = 0;
   logic [1:0]    wr_sel = 0;
   logic [W-1:0]  wr_data = 0;
   logic [NB-1:0] wr_be = 0;
   logic [1:0]    hold_mode = 0, hclr = 0;
   logic [W-1:0]  count_o, latch_o;
   logic [1:0]    eq_n_o, match_o;

   always #4 clk = ~clk;

   poscnt_unit u_poscnt_unit (
      .clk(clk), .rst_n(rst_n), .step_en(step_en), .step_dir(step_dir),
      .ld_stb(ld_stb), .lt_stb(lt_stb), .clr_mode(clr_mode),
      .a_in(a_in), .b_in(b_in), .z_in(z_in), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .wr_be(wr_be),
      .hold_mode(hold_mode), .hclr(hclr), .count_o(count_o),
      .latch_o(latch_o), .eq_n_o(eq_n_o), .match_o(match_o)
   );

   typedef struct {
      logic [W-1:0] cnt;
      logic [W-1:0] lat;
      logic [1:0]   match;
      logic [1:0]   eqn;
      string        tag;
   } exp_t;

   exp_t q[$];
   int   n_chk = 0;
   int   n_fail = 0;
   bit   done = 0;

   // reference model state
   logic [W-1:0] m_cnt = 0, m_lat = 0, m_pre = 0;
   logic [W-1:0] m_ref [2];
   logic [1:0]   m_held = 0;
   logic         m_preva = 0;

   function automatic logic [W-1:0] merge(logic [W-1:0] old, logic [W-1:0] d,
                                          logic [NB-1:0] be);
      logic [W-1:0] r = old;
      for (int k = 0; k < NB; k++) if (be[k]) r[k*8 +: 8] = d[k*8 +: 8];
      return r;
   endfunction

   // one clock: model the edge from current inputs, push expectation
   task automatic cyc(input bit push, input string tag);
      exp_t e;
      logic hit;
      logic [W-1:0] nc;
      if (!rst_n) begin
         m_cnt = 0; m_lat = 0; m_pre = 0; m_held = 0; m_preva = 0;
         if (wr_en && wr_sel == 2'd1) m_ref[0] = merge(m_ref[0], wr_data, wr_be);
         if (wr_en && wr_sel == 2'd2) m_ref[1] = merge(m_ref[1], wr_data, wr_be);
      end else begin
         hit = clr_mode && z_in && !b_in && (a_in != m_preva);
         nc  = hit ? '0 : ld_stb ? m_pre :
               step_en ? (step_dir ? m_cnt + 1 : m_cnt - 1) & MSK : m_cnt;
         for (int i = 0; i < 2; i++)
            if (hclr[i]) m_held[i] = 1'b0;
            else if (m_cnt == m_ref[i]) m_held[i] = 1'b1;
         if (lt_stb) m_lat = m_cnt;
         if (wr_en && wr_sel == 2'd0) m_pre    = merge(m_pre,    wr_data, wr_be);
         if (wr_en && wr_sel == 2'd1) m_ref[0] = merge(m_ref[0], wr_data, wr_be);
         if (wr_en && wr_sel == 2'd2) m_ref[1] = merge(m_ref[1], wr_data, wr_be);
         m_preva = a_in;
         m_cnt = nc;
      end
      if (push && rst_n) begin
         e.cnt = m_cnt; e.lat = m_lat; e.tag = tag;
         for (int i = 0; i < 2; i++) begin
            e.eqn[i]   = !(m_cnt == m_ref[i]);
            e.match[i] = hold_mode[i] ? (m_held[i] || !e.eqn[i]) : !e.eqn[i];
         end
         q.push_back(e);
      end
      @(negedge clk);
      step_en = 0; ld_stb = 0; lt_stb = 0; wr_en = 0; hclr = 0;
   endtask

   task automatic wr(input logic [1:0] s, input logic [W-1:0] d,
                     input logic [NB-1:0] be, input bit push, input string tag);
      wr_en = 1; wr_sel = s; wr_data = d; wr_be = be;
      cyc(push, tag);
   endtask

   task automatic step(input logic dir, input string tag);
      step_en = 1; step_dir = dir;
      cyc(1, tag);
   endtask

   task automatic chk(input bit ok, input string tag, input logic [W-1:0] act,
                      input logic [W-1:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // monitor: compares each expectation after its edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         if (q.size() > 0) begin
            exp_t e;
            bit ok;
            e = q.pop_front();
            ok = (count_o == e.cnt) && (latch_o == e.lat) &&
                 (match_o == e.match) && (eq_n_o == e.eqn);
            n_chk++;
            if (!ok) begin
               n_fail++;
               $display("FAIL %s cnt=%h/%h lat=%h/%h match=%b/%b eqn=%b/%b (actual/expected)",
                        e.tag, count_o, e.cnt, latch_o, e.lat, match_o, e.match,
                        eq_n_o, e.eqn);
            end
         end
      end
   end

   initial begin
      #(8 * 100000);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      m_ref[0] = 0; m_ref[1] = 0;
      @(negedge clk);
      // references written while reset is held (R10 groundwork)
      wr(2'd1, 24'h000005, 3'b111, 0, "R6");
      wr(2'd2, 24'hFFFFFE, 3'b111, 0, "R6");
      cyc(0, "rst");
      rst_n = 1;
      #1;
      chk(count_o == 0, "R1 count after reset", count_o, 0);
      chk(latch_o == 0, "R1 latch after reset", latch_o, 0);
      chk(match_o == 2'b00, "R1 match after reset", W'(match_o), 0);

      // R2 up-count through reference 0, R7/R8 momentary match
      for (int n = 0; n < 6; n++) step(1, "R2_R7_R8 up through ref0");

      // R9 held match on reference 1 across the wrap
      hold_mode = 2'b10;
      wr(2'd0, 24'hFFFFFD, 3'b111, 1, "R6 preload write");
      ld_stb = 1; cyc(1, "R3 load");
      step(1, "R9 reach ref1");
      step(1, "R9 held after pass");
      step(1, "R2 wrap up to zero");
      hclr = 2'b10; cyc(1, "R9 release");
      step(0, "R2 wrap down to ones");
      step(0, "R9 rearm at ref1");
      hclr = 2'b10; cyc(1, "R9 clear while equal");
      step(1, "R9 released after move");

      // R3 load beats step
      ld_stb = 1; step_en = 1; step_dir = 1; cyc(1, "R3 load over step");
      // R6 middle byte only
      wr(2'd0, 24'hABCDEF, 3'b010, 1, "R6 partial write");
      ld_stb = 1; cyc(1, "R6 partial preload loaded");
      // R4 latch with simultaneous step
      lt_stb = 1; step_en = 1; step_dir = 0; cyc(1, "R4 latch with step");
      step(1, "R4 latch holds");

      // R5 qualified clear
      clr_mode = 1; z_in = 1; b_in = 0;
      a_in = 1; cyc(1, "R5 clear on rising A");
      step(1, "R5 count after clear");
      b_in = 1; a_in = 0; step(1, "R5 no clear with B high");
      b_in = 0; z_in = 0; a_in = 1; step(1, "R5 no clear with Z low");
      z_in = 1; a_in = 0; ld_stb = 1; cyc(1, "R5 clear over load");
      clr_mode = 0; a_in = 1; step(1, "R5 disabled");

      // R10 references survive a second reset
      rst_n = 0;
      cyc(0, "rst2"); cyc(0, "rst2");
      rst_n = 1;
      hold_mode = 2'b01;
      for (int n = 0; n < 6; n++) step(1, "R10 ref0 kept");
      hclr = 2'b01; cyc(1, "R9 ref0 release");

      repeat (3) @(negedge clk);
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

endmodule